// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block gives software control over 32 general-purpose pins through a simple synchronous register bus. Each pin can be an input or an output. An output pin drives either both levels or, in open-drain mode, low only, and releases the line for a logic one. The output latch is written for every pin, whatever its direction. A read of the data register gives the pad level for input pins and the latch for output pins.

Pad inputs pass through a two-flop synchronizer. Transitions are detected on the synchronized value. A per-pin sense bit chooses between recording both edges and recording falling edges only. Recorded events stay pending until software clears them by writing ones. A per-pin mask enables each pin's pending event onto one combined interrupt line. The register bits are numbered so that pin 0 sits in the most significant bit. The pad-side vectors are indexed by pin number.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Pin n maps to register bit (31 − n) in every register, while the pad vectors `pad_in`, `pad_out` and `pad_oe` carry pin n at index n.
- R2: The byte offsets are: 0x00 direction, 0x04 open-drain enable, 0x08 data, 0x0C event, 0x10 mask, 0x14 edge sense. Only `bus_addr[4:2]` is decoded. `bus_rdata` is registered: it is valid in the cycle after `bus_rd` and holds until the next read. Offsets 0x18 and 0x1C read as zero, and writes to them change no register.
- R3: A direction bit of 1 makes the pin an output. An input pin always has `pad_oe` low.
- R4: A data register read returns, bit by bit, the synchronized pad value where the direction bit is 0 and the output latch where it is 1.
- R5: A data register write loads the latch for all 32 bits, including input pins. A later switch of a pin to output drives the stored value.
- R6: An output pin with its open-drain bit set has `pad_out` = 0 and `pad_oe` = NOT latch. With the open-drain bit clear, it has `pad_oe` = 1 and `pad_out` = latch. Pad outputs reflect a register write in the cycle after it.
- R7: A pad change applied before clock edge k sets the event bit at edge k+2 (two synchronizer stages plus the previous-value compare).
- R8: An edge-sense bit of 0 records both rising and falling edges. A bit of 1 records falling edges only.
- R9: Writing the event register clears every bit written as 1 and leaves bits written as 0 unchanged. A write of all ones clears every pending event.
- R10: When a pin's new edge and a clearing write of its event bit fall in the same cycle, the bit stays set.
- R11: `irq` is 1 exactly when the event register AND the mask register is non-zero, in the same cycle as those registers.
- R12: Reset clears every register, the synchronizer, `pad_oe`, `pad_out`, `bus_rdata` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels, index = pin |
| pad_out | output | 32 | Pad output values, index = pin |
| pad_oe | output | 32 | Pad output enables, index = pin |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can act on one event bit in the same cycle: the edge detector setting it and a software write clearing it. The bench provokes this by changing a pin's pad exactly two clock edges before a write to the event register. That write clears the stale event of a second pin at the same moment. The event register is then read back. The colliding bit must still be set and the neighbouring bit must be clear. An assertion also checks, on every clearing write, that only bits with no concurrent edge are cleared.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned GPIO_PINS   = 32;
  localparam int unsigned GPIO_ADDR_W = 5;
  localparam int unsigned SYNC_DEPTH  = 2;

  // word index of each register (byte offset / 4)
  localparam int unsigned IDX_DIR = 0;
  localparam int unsigned IDX_ODE = 1;
  localparam int unsigned IDX_LAT = 2;
  localparam int unsigned IDX_EVT = 3;
  localparam int unsigned IDX_MSK = 4;
  localparam int unsigned IDX_SNS = 5;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] sync_o
);
  // reorder pads into register order: pin n -> bit NPINS-1-n
  logic [NPINS-1:0] pad_reg_order;
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar i = 0; i < NPINS; i++) begin : g_rev
    assign pad_reg_order[NPINS-1-i] = pad_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pad_reg_order;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] fall_only_i,
  output logic [NPINS-1:0] edge_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] fall;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  assign rise   = sync_i & ~prev_q;
  assign fall   = prev_q & ~sync_i;
  assign edge_o = fall | (rise & ~fall_only_i);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NPINS-1:0]  edge_i,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  ode_q,
  output logic [NPINS-1:0]  lat_q,
  output logic [NPINS-1:0]  evt_q,
  output logic [NPINS-1:0]  msk_q,
  output logic [NPINS-1:0]  sns_q,
  output logic [NPINS-1:0]  dir_n,
  output logic [NPINS-1:0]  ode_n,
  output logic [NPINS-1:0]  lat_n,
  output logic [NPINS-1:0]  evt_n,
  output logic [NPINS-1:0]  msk_n
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic [1:0]       unused_lsb;
  logic [NPINS-1:0] sns_n;
  logic [NPINS-1:0] clr_mask;
  logic [NPINS-1:0] data_view;
  logic [NPINS-1:0] rd_n;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = bus_addr[1:0];

  function automatic logic hit(input logic [IDX_W-1:0] a, input int unsigned idx);
    return int'(a) == int'(idx);
  endfunction

  always_comb begin
    dir_n = dir_q;
    ode_n = ode_q;
    lat_n = lat_q;
    msk_n = msk_q;
    sns_n = sns_q;
    clr_mask = '0;
    if (bus_wr) begin
      if (hit(widx, IDX_DIR)) dir_n = bus_wdata;
      if (hit(widx, IDX_ODE)) ode_n = bus_wdata;
      if (hit(widx, IDX_LAT)) lat_n = bus_wdata;
      if (hit(widx, IDX_MSK)) msk_n = bus_wdata;
      if (hit(widx, IDX_SNS)) sns_n = bus_wdata;
      if (hit(widx, IDX_EVT)) clr_mask = bus_wdata;
    end
    // a fresh edge outranks a same-cycle clear
    evt_n = (evt_q & ~clr_mask) | edge_i;
  end

  assign data_view = (sync_i & ~dir_q) | (lat_q & dir_q);

  always_comb begin
    rd_n = '0;
    unique case (int'(widx))
      IDX_DIR: rd_n = dir_q;
      IDX_ODE: rd_n = ode_q;
      IDX_LAT: rd_n = data_view;
      IDX_EVT: rd_n = evt_q;
      IDX_MSK: rd_n = msk_q;
      IDX_SNS: rd_n = sns_q;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      ode_q     <= '0;
      lat_q     <= '0;
      evt_q     <= '0;
      msk_q     <= '0;
      sns_q     <= '0;
      bus_rdata <= '0;
    end else begin
      dir_q <= dir_n;
      ode_q <= ode_n;
      lat_q <= lat_n;
      evt_q <= evt_n;
      msk_q <= msk_n;
      sns_q <= sns_n;
      if (bus_rd) bus_rdata <= rd_n;
    end
  end
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_n,
  input  logic [NPINS-1:0] ode_n,
  input  logic [NPINS-1:0] lat_n,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic [NPINS-1:0] out_n;
  logic [NPINS-1:0] oe_n;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int unsigned RB = NPINS - 1 - i;
    assign out_n[i] = lat_n[RB] & ~ode_n[RB];
    assign oe_n[i]  = dir_n[RB] & ~(ode_n[RB] & lat_n[RB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
    end else begin
      pad_out <= out_n;
      pad_oe  <= oe_n;
    end
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS  = GPIO_PINS,
  parameter int unsigned ADDR_W = GPIO_ADDR_W,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] edge_vec;
  logic [NPINS-1:0] dir_q, ode_q, lat_q, evt_q, msk_q, sns_q;
  logic [NPINS-1:0] dir_n, ode_n, lat_n, evt_n, msk_n;

  gpio_in_sync #(.NPINS(NPINS), .STAGES(STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .sync_o (sync_q)
  );

  gpio_edge_det #(.NPINS(NPINS)) u_edge (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_q),
    .fall_only_i (sns_q),
    .edge_o      (edge_vec)
  );

  gpio_regfile #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .sync_i    (sync_q),
    .edge_i    (edge_vec),
    .dir_q     (dir_q),
    .ode_q     (ode_q),
    .lat_q     (lat_q),
    .evt_q     (evt_q),
    .msk_q     (msk_q),
    .sns_q     (sns_q),
    .dir_n     (dir_n),
    .ode_n     (ode_n),
    .lat_n     (lat_n),
    .evt_n     (evt_n),
    .msk_n     (msk_n)
  );

  gpio_pad_drv #(.NPINS(NPINS)) u_pads (
    .clk     (clk),
    .rst     (rst),
    .dir_n   (dir_n),
    .ode_n   (ode_n),
    .lat_n   (lat_n),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  // registered from next-state values so it lines up with the registers
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(evt_n & msk_n);
  end
endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  ode_q,
  input logic [NPINS-1:0]  evt_q,
  input logic [NPINS-1:0]  msk_q,
  input logic [NPINS-1:0]  sns_q,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  edge_vec,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic              irq
);
  logic [NPINS-1:0] dir_pin, ode_pin;
  logic             evt_wr;

  for (genvar i = 0; i < NPINS; i++) begin : g_rev
    assign dir_pin[i] = dir_q[NPINS-1-i];
    assign ode_pin[i] = ode_q[NPINS-1-i];
  end

  assign evt_wr = bus_wr && (int'(bus_addr[ADDR_W-1:2]) == 3);

  p_irq_match_r11: assert property (@(posedge clk) disable iff (rst)
    irq == |(evt_q & msk_q));

  p_oe_input_r3: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & ~dir_pin) == '0);

  p_od_low_r6: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ode_pin) == '0);

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (edge_vec != '0) |=> ((evt_q & $past(edge_vec)) == $past(edge_vec)));

  p_fall_only_r8: assert property (@(posedge clk) disable iff (rst)
    (edge_vec & sns_q & sync_q) == '0);

  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    evt_wr |=> ((evt_q & $past(bus_wdata & ~edge_vec)) == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .dir_q     (dir_q),
  .ode_q     (ode_q),
  .evt_q     (evt_q),
  .msk_q     (msk_q),
  .sns_q     (sns_q),
  .sync_q    (sync_q),
  .edge_vec  (edge_vec),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq)
);

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  localparam logic [4:0] A_DIR = 5'h00, A_ODE = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_SNS = 5'h14, A_NONE = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int nvec = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] pinbit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    pats[0] = 32'hA5C3_0F96; pats[1] = 32'h0000_0001;
    pats[2] = 32'h8000_0000; pats[3] = 32'h3C5A_F00F;

    idle(3);
    rst = 1'b0;
    idle(1);

    // R12 reset state
    chk("R12 pad_oe", pad_oe, '0);
    chk("R12 pad_out", pad_out, '0);
    chk("R12 irq", {31'b0, irq}, '0);
    foreach (pats[k]) begin end
    for (int a = 0; a < 6; a++) begin
      rd(5'(a*4), v);
      chk("R12 register zero", v, '0);
    end

    // R2 read/write of plain registers, unmapped offset
    foreach (pats[k]) begin
      wr(A_ODE, pats[k]); rd(A_ODE, v); chk("R2 open-drain rw", v, pats[k]);
      wr(A_MSK, ~pats[k]); rd(A_MSK, v); chk("R2 mask rw", v, ~pats[k]);
      wr(A_SNS, pats[k]); rd(A_SNS, v); chk("R2 sense rw", v, pats[k]);
    end
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, v); chk("R2 unmapped reads zero", v, '0);
    rd(A_SNS, v);  chk("R2 unmapped write ignored", v, pats[3]);
    wr(A_ODE, '0); wr(A_MSK, '0); wr(A_SNS, '0);

    // R1 R3 R6 push-pull drive, one output pin at a time
    wr(A_DAT, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      wr(A_DIR, pinbit(n));
      chk("R1 R3 single output enable", pad_oe, 32'(1) << n);
      chk("R6 push-pull drives latch", pad_out & pad_oe, 32'(1) << n);
    end

    // R5 latch written while input, driven after direction change
    wr(A_DIR, '0);
    wr(A_DAT, pats[0]);
    chk("R3 inputs never enabled", pad_oe, '0);
    wr(A_DIR, 32'hFFFF_FFFF);
    chk("R5 retained latch driven", pad_out, rev(pats[0]));
    chk("R5 all outputs enabled", pad_oe, 32'hFFFF_FFFF);

    // R6 open drain
    foreach (pats[k]) begin
      wr(A_DAT, pats[k]);
      wr(A_ODE, 32'hFFFF_FFFF);
      chk("R6 open-drain output value", pad_out, '0);
      chk("R6 open-drain enable", pad_oe, rev(~pats[k]));
      wr(A_ODE, '0);
    end

    // R4 mixed data read
    foreach (pats[k]) begin
      logic [31:0] d, l, p;
      d = pats[k]; l = pats[(k+1)%4]; p = pats[(k+2)%4] ^ 32'h1234_5678;
      wr(A_DIR, d); wr(A_DAT, l);
      pad_in = p;
      idle(3);
      rd(A_DAT, v);
      chk("R4 data mix", v, (rev(p) & ~d) | (l & d));
    end
    wr(A_DIR, '0);
    pad_in = '0;
    idle(4);
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, v); chk("R9 clear all", v, '0);

    // R7 R11 latency: event visible on irq at third edge
    wr(A_MSK, 32'hFFFF_FFFF);
    pad_in[3] = 1'b1;
    idle(1); chk("R7 no event after 1 edge", {31'b0, irq}, '0);
    idle(1); chk("R7 no event after 2 edges", {31'b0, irq}, '0);
    idle(1); chk("R7 R11 event at 3rd edge", {31'b0, irq}, 32'd1);
    wr(A_MSK, ~pinbit(3));
    chk("R11 masked pin", {31'b0, irq}, '0);
    wr(A_MSK, '0);
    wr(A_EVT, 32'hFFFF_FFFF);
    pad_in[3] = 1'b0; idle(4);
    wr(A_EVT, 32'hFFFF_FFFF);

    // R8 R1 per-pin sweep of both sense modes
    for (int s = 0; s < 2; s++) begin
      wr(A_SNS, s ? 32'hFFFF_FFFF : 32'h0);
      for (int n = 0; n < 32; n++) begin
        pad_in[n] = 1'b1; idle(4);
        rd(A_EVT, v);
        chk(s ? "R8 rising ignored when falling-only" : "R8 R1 rising recorded", v, s ? 32'h0 : pinbit(n));
        wr(A_EVT, 32'hFFFF_FFFF);
        pad_in[n] = 1'b0; idle(4);
        rd(A_EVT, v);
        chk("R8 R1 falling recorded", v, pinbit(n));
        wr(A_EVT, 32'hFFFF_FFFF);
      end
    end
    wr(A_SNS, '0);

    // R9 partial clear and zero write
    pad_in = 32'h0000_00FF; idle(4);
    rd(A_EVT, v); chk("R9 events pending", v, 32'hFF00_0000);
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); chk("R9 zero write no effect", v, 32'hFF00_0000);
    wr(A_EVT, 32'h3C00_0000);
    rd(A_EVT, v); chk("R9 partial clear", v, 32'hC300_0000);
    wr(A_MSK, 32'h0300_0000);
    chk("R11 irq with masked pending", {31'b0, irq}, 32'd1);
    wr(A_EVT, 32'hFFFF_FFFF);
    chk("R11 irq drops after clear", {31'b0, irq}, '0);
    chk("R9 irq clear-all", {31'b0, irq}, '0);
    wr(A_MSK, '0);
    pad_in = '0; idle(4);
    wr(A_EVT, 32'hFFFF_FFFF);

    // R10 edge collides with clear of same bit
    pad_in[5] = 1'b1; pad_in[6] = 1'b1; idle(4);
    rd(A_EVT, v); chk("R10 setup", v, pinbit(5) | pinbit(6));
    pad_in[5] = 1'b0;
    idle(2);
    wr(A_EVT, pinbit(5) | pinbit(6));
    rd(A_EVT, v); chk("R10 new edge beats clear", v, pinbit(5));

    finish_run();
  end
endmodule